// File: doc/BRIEF.md
# SLA-Capped Two-Phase Upstream Grant Scheduler

This block sits in the head-end of a passive optical network and decides how much upstream time each remote unit may use in one allocation cycle. A cycle opens with a start pulse that loads the cycle's capacity and the set of active units. Each active unit then presents one summed queue request. The block answers each request at once with a first grant, limited by the unit's configured service-level limit and by the capacity still left. A unit that asked for no more than its limit is finished with that single grant. A unit that asked for more is remembered together with its excess.

When every active unit has been served once, a second pass visits the over-limit units in rotating order. Each gets what is left of its excess, clipped to the remaining capacity, down to zero. A force-report flag travels with every grant. It is set on the grant that is the unit's last in the cycle, so the unit reports again, and cleared on a first grant that will be followed by a second one. After the last grant has left the output port, a one-clock done pulse closes the cycle and the per-unit excess state is cleared.

Limits are written through a simple configuration port. Grants leave on a valid/ready port that holds one grant at a time. Requests enter on a valid/ready port at up to one per clock.

Top module: `sla_grant_sched`

## Requirements
- R1: A request accepted (req_valid and req_ready high at a clock edge) from an eligible unit puts a grant for that same unit on the output, with gate_valid high, right after that edge. Other units' requests are not waited for.
- R2: The first grant size is the smallest of three values: the request, the unit's limit, and the capacity remaining in the cycle.
- R3: A first grant has gate_force = 1 when the request is at or below the unit's limit, and that unit receives no other grant in the cycle. A first grant has gate_force = 0 when the request exceeds the limit.
- R4: After all active units have been served once, each over-limit unit receives exactly one second grant with gate_force = 1. Its size is the smaller of (request minus limit) and the remaining capacity, and zero-sized grants are still issued.
- R5: Second grants are issued in ascending unit order modulo N_UNITS, starting at a rotating pointer. The pointer is 0 after reset and advances by one, wrapping from N_UNITS-1 to 0, at every cycle_done.
- R6: On a cycle_start while idle, the remaining capacity loads from cycle_cap and active_mask is latched. Each grant reduces the remaining capacity, so the grants of one cycle never sum above cycle_cap. A cycle_start outside idle is ignored.
- R7: A request whose unit ID is N_UNITS or above, whose unit is inactive in the latched mask, or whose unit already has a grant this cycle is consumed and produces no grant.
- R8: req_ready is high only while the block is taking requests and its output slot is empty or being emptied at that edge. It is low while idle and while a grant waits on a low gate_ready.
- R9: While gate_valid is high and gate_ready is low, gate_valid, gate_unit, gate_size and gate_force hold their values.
- R10: cycle_done pulses for one clock after the cycle's last grant has been accepted, with gate_valid low. A cycle with no over-limit unit, including one with an empty mask, ends as soon as its first-phase grants drain. The block is then idle with no excess pending.
- R11: cfg_we writes cfg_limit as the limit of unit cfg_unit, and the new value applies to requests accepted on later clocks. All limits are zero after reset.
- R12: After reset, gate_valid, cycle_done and req_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_start | input | 1 | Opens an allocation cycle when the block is idle |
| cycle_cap | input | VAL_W | Capacity of the cycle, sampled with cycle_start |
| active_mask | input | N_UNITS | Units taking part in the cycle, sampled with cycle_start |
| cfg_we | input | 1 | Limit write strobe |
| cfg_unit | input | ID_W | Unit whose limit is written |
| cfg_limit | input | VAL_W | Limit value written |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge when req_valid is high |
| req_unit | input | ID_W | Requesting unit |
| req_bytes | input | VAL_W | Summed queue request of the unit |
| gate_valid | output | 1 | Grant present |
| gate_ready | input | 1 | Downstream takes the grant |
| gate_unit | output | ID_W | Unit receiving the grant |
| gate_size | output | VAL_W | Granted amount |
| gate_force | output | 1 | Unit must report again for the next cycle |
| cycle_done | output | 1 | One-clock pulse closing the cycle |

## Verification
On every clock the assertions check the following: an eligible accepted request is followed by a grant for that unit that never exceeds the unit's limit; the remaining capacity never grows except when a cycle opens; a stalled grant holds still; and the done pulse arrives only with an empty output slot, no pending excess and the block idle. The bench's scenarios show the rest. These are the exact first and second grant sizes and flags, and the rotating order of the excess pass across cycles with a moving pointer. They also cover clipping to zero when capacity runs out, requests that are ignored, a start pulse ignored mid-cycle, limits rewritten between cycles, and cycles with no over-limit unit or no active unit at all.

// File: rtl/sgs_pkg.sv
`timescale 1ns/1ps
package sgs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REQ    = 2'd1,
        ST_EXCESS = 2'd2
    } sgs_state_e;

endpackage

// File: rtl/sgs_sla_table.sv
`timescale 1ns/1ps
module sgs_sla_table #(
    parameter int N_UNITS = 6,
    parameter int VAL_W   = 16,
    localparam int ID_W   = $clog2(N_UNITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ID_W-1:0]  wr_unit,
    input  logic [VAL_W-1:0] wr_limit,
    input  logic [ID_W-1:0]  rd_unit,
    output logic [VAL_W-1:0] rd_limit
);

    logic [VAL_W-1:0] lim_d [N_UNITS];
    logic [VAL_W-1:0] lim_q [N_UNITS];

    for (genvar i = 0; i < N_UNITS; i++) begin : g_slot
        always_comb begin
            lim_d[i] = lim_q[i];
            if (wr_en && (int'(wr_unit) == i)) begin
                lim_d[i] = wr_limit;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lim_q[i] <= '0;
            end else begin
                lim_q[i] <= lim_d[i];
            end
        end
    end

    always_comb begin
        rd_limit = '0;
        if (int'(rd_unit) < N_UNITS) begin
            rd_limit = lim_q[rd_unit];
        end
    end

endmodule

// File: rtl/sgs_grant_calc.sv
`timescale 1ns/1ps
module sgs_grant_calc #(
    parameter int VAL_W = 16
) (
    input  logic [VAL_W-1:0] req,
    input  logic [VAL_W-1:0] limit,
    input  logic [VAL_W-1:0] remain,
    output logic [VAL_W-1:0] grant,
    output logic             over,
    output logic [VAL_W-1:0] excess
);

    logic [VAL_W-1:0] capped;

    always_comb begin
        over   = (req > limit);
        capped = over ? limit : req;
        grant  = (capped > remain) ? remain : capped;
        excess = over ? (req - limit) : '0;
    end

endmodule

// File: rtl/sla_grant_sched.sv
`timescale 1ns/1ps
module sla_grant_sched #(
    parameter int N_UNITS = 6,
    parameter int VAL_W   = 16,
    localparam int ID_W   = $clog2(N_UNITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cycle_start,
    input  logic [VAL_W-1:0]   cycle_cap,
    input  logic [N_UNITS-1:0] active_mask,
    input  logic               cfg_we,
    input  logic [ID_W-1:0]    cfg_unit,
    input  logic [VAL_W-1:0]   cfg_limit,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ID_W-1:0]    req_unit,
    input  logic [VAL_W-1:0]   req_bytes,
    output logic               gate_valid,
    input  logic               gate_ready,
    output logic [ID_W-1:0]    gate_unit,
    output logic [VAL_W-1:0]   gate_size,
    output logic               gate_force,
    output logic               cycle_done
);

    import sgs_pkg::*;

    localparam int CNT_W = ID_W + 1;

    typedef struct packed {
        sgs_state_e                      state;
        logic [VAL_W-1:0]                remain;
        logic [N_UNITS-1:0]              active;
        logic [N_UNITS-1:0]              seen;
        logic [N_UNITS-1:0]              over;
        logic [N_UNITS-1:0][VAL_W-1:0]   excess;
        logic [ID_W-1:0]                 ptr;
        logic [CNT_W-1:0]                idx;
        logic                            gvalid;
        logic [ID_W-1:0]                 gunit;
        logic [VAL_W-1:0]                gsize;
        logic                            gforce;
        logic                            done;
    } regs_t;

    regs_t r_d, r_q;

    // Limit storage and first-grant arithmetic
    logic [VAL_W-1:0] sla_rd;
    logic [VAL_W-1:0] first_grant;
    logic [VAL_W-1:0] first_excess;
    logic             first_over;

    sgs_sla_table #(.N_UNITS(N_UNITS), .VAL_W(VAL_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_unit  (cfg_unit),
        .wr_limit (cfg_limit),
        .rd_unit  (req_unit),
        .rd_limit (sla_rd)
    );

    sgs_grant_calc #(.VAL_W(VAL_W)) u_calc (
        .req    (req_bytes),
        .limit  (sla_rd),
        .remain (r_q.remain),
        .grant  (first_grant),
        .over   (first_over),
        .excess (first_excess)
    );

    // Shared decode
    logic             slot_free;
    logic             first_ok;
    logic [ID_W-1:0]  rr_unit;
    logic [ID_W-1:0]  ptr_next;
    logic [VAL_W-1:0] second_grant;
    logic             req_ready_c;

    always_comb begin
        int s;
        slot_free = !r_q.gvalid || gate_ready;
        first_ok  = (int'(req_unit) < N_UNITS) && r_q.active[req_unit] && !r_q.seen[req_unit];
        s = int'(r_q.ptr) + int'(r_q.idx);
        if (s >= N_UNITS) begin
            s = s - N_UNITS;
        end
        rr_unit  = ID_W'(s);
        ptr_next = (r_q.ptr == ID_W'(N_UNITS - 1)) ? '0 : r_q.ptr + ID_W'(1);
        second_grant = (r_q.excess[rr_unit] > r_q.remain) ? r_q.remain : r_q.excess[rr_unit];
    end

    // Next-state logic
    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        req_ready_c = 1'b0;
        if (r_q.gvalid && gate_ready) begin
            r_d.gvalid = 1'b0;
        end

        case (r_q.state)
            ST_IDLE: begin
                if (cycle_start) begin
                    r_d.state  = ST_REQ;
                    r_d.remain = cycle_cap;
                    r_d.active = active_mask;
                    r_d.seen   = '0;
                    r_d.over   = '0;
                end
            end

            ST_REQ: begin
                if (r_q.seen == r_q.active) begin
                    if (r_q.over == '0) begin
                        if (slot_free) begin
                            r_d.state  = ST_IDLE;
                            r_d.done   = 1'b1;
                            r_d.ptr    = ptr_next;
                            r_d.excess = '0;
                        end
                    end else begin
                        r_d.state = ST_EXCESS;
                        r_d.idx   = '0;
                    end
                end else begin
                    req_ready_c = slot_free;
                    if (req_valid && slot_free && first_ok) begin
                        r_d.seen[req_unit] = 1'b1;
                        r_d.gvalid         = 1'b1;
                        r_d.gunit          = req_unit;
                        r_d.gsize          = first_grant;
                        r_d.gforce         = !first_over;
                        r_d.remain         = r_q.remain - first_grant;
                        if (first_over) begin
                            r_d.over[req_unit]   = 1'b1;
                            r_d.excess[req_unit] = first_excess;
                        end
                    end
                end
            end

            ST_EXCESS: begin
                if (r_q.idx == CNT_W'(N_UNITS)) begin
                    if (slot_free) begin
                        r_d.state  = ST_IDLE;
                        r_d.done   = 1'b1;
                        r_d.ptr    = ptr_next;
                        r_d.over   = '0;
                        r_d.excess = '0;
                    end
                end else if (r_q.over[rr_unit]) begin
                    if (slot_free) begin
                        r_d.gvalid        = 1'b1;
                        r_d.gunit         = rr_unit;
                        r_d.gsize         = second_grant;
                        r_d.gforce        = 1'b1;
                        r_d.remain        = r_q.remain - second_grant;
                        r_d.over[rr_unit] = 1'b0;
                        r_d.idx           = r_q.idx + CNT_W'(1);
                    end
                end else begin
                    r_d.idx = r_q.idx + CNT_W'(1);
                end
            end

            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = req_ready_c;
    assign gate_valid = r_q.gvalid;
    assign gate_unit  = r_q.gunit;
    assign gate_size  = r_q.gsize;
    assign gate_force = r_q.gforce;
    assign cycle_done = r_q.done;

    // Checks next to the logic they guard
    assert_grant_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && first_ok) |=> (gate_valid && gate_unit == $past(req_unit)));

    assert_first_within_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && first_ok) |=> (gate_size <= $past(sla_rd)));

    assert_remain_no_growth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.state == ST_IDLE && cycle_start) |=> (r_q.remain <= $past(r_q.remain)));

    assert_gate_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_valid && !gate_ready) |=> (gate_valid && $stable(gate_unit)
                                         && $stable(gate_size) && $stable(gate_force)));

    assert_done_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> (!gate_valid && r_q.over == '0 && r_q.state == ST_IDLE));

endmodule

// File: tb/sla_grant_sched_bench.sv
`timescale 1ns/1ps
module sla_grant_sched_bench;

    localparam int N  = 6;
    localparam int W  = 16;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cycle_start = 1'b0;
    logic [W-1:0]  cycle_cap = '0;
    logic [N-1:0]  active_mask = '0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_unit = '0;
    logic [W-1:0]  cfg_limit = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [IW-1:0] req_unit = '0;
    logic [W-1:0]  req_bytes = '0;
    logic          gate_valid;
    logic          gate_ready = 1'b1;
    logic [IW-1:0] gate_unit;
    logic [W-1:0]  gate_size;
    logic          gate_force;
    logic          cycle_done;

    always #2.5 clk = ~clk;

    sla_grant_sched #(.N_UNITS(N), .VAL_W(W)) u_sla_grant_sched (
        .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .cycle_cap(cycle_cap),
        .active_mask(active_mask), .cfg_we(cfg_we), .cfg_unit(cfg_unit), .cfg_limit(cfg_limit),
        .req_valid(req_valid), .req_ready(req_ready), .req_unit(req_unit), .req_bytes(req_bytes),
        .gate_valid(gate_valid), .gate_ready(gate_ready), .gate_unit(gate_unit),
        .gate_size(gate_size), .gate_force(gate_force), .cycle_done(cycle_done)
    );

    int checks = 0;
    int errors = 0;

    // Behavioural reference state
    int    lim_m [N];
    int    ptr_m = 0;
    int    remain_m;
    int    cap_m = 0;
    bit    act_m [N];
    bit    seen_m [N];
    bit    over_m [N];
    int    ex_m [N];
    int    exp_u [$];
    int    exp_s [$];
    int    exp_f [$];
    string exp_t [$];
    int    done_cnt = 0;
    int    granted = 0;
    bit    bp_en = 1'b0;
    int    bp_ctr = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %s expected %s", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Output backpressure pattern
    always @(negedge clk) begin
        bp_ctr++;
        gate_ready = bp_en ? ((bp_ctr % 3) != 0) : 1'b1;
    end

    // Per-clock comparison against the expected grant stream
    bit            stall_prev = 1'b0;
    logic [IW-1:0] pu;
    logic [W-1:0]  ps;
    logic          pf;

    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (stall_prev) begin
                chk(gate_valid && gate_unit == pu && gate_size == ps && gate_force == pf,
                    "R9", "stalled grant held", $sformatf("%0d/%0d", gate_unit, gate_size),
                    $sformatf("%0d/%0d", pu, ps));
            end
            if (gate_valid && !gate_ready) begin
                chk(!req_ready, "R8", "req_ready with blocked output",
                    $sformatf("%0d", req_ready), "0");
            end
            if (gate_valid && gate_ready) begin
                if (exp_u.size() == 0) begin
                    chk(1'b0, "R7", "unexpected grant", $sformatf("unit %0d", gate_unit), "none");
                end else begin
                    int eu, es, ef;
                    string et;
                    eu = exp_u.pop_front(); es = exp_s.pop_front();
                    ef = exp_f.pop_front(); et = exp_t.pop_front();
                    chk(int'(gate_unit) == eu && int'(gate_size) == es && int'(gate_force) == ef,
                        et, "grant unit/size/force",
                        $sformatf("%0d/%0d/%0d", gate_unit, gate_size, gate_force),
                        $sformatf("%0d/%0d/%0d", eu, es, ef));
                    granted += int'(gate_size);
                    chk(granted <= cap_m, "R6", "cycle total within capacity",
                        $sformatf("%0d", granted), $sformatf("<=%0d", cap_m));
                end
            end
            if (cycle_done) begin
                done_cnt++;
                chk(!gate_valid && exp_u.size() == 0, "R10", "done with all grants out",
                    $sformatf("valid %0d left %0d", gate_valid, exp_u.size()), "valid 0 left 0");
                granted = 0;
            end
            stall_prev = gate_valid && !gate_ready;
            pu = gate_unit; ps = gate_size; pf = gate_force;
        end
    end

    task automatic set_limit(input int u, input int v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_unit = IW'(u); cfg_limit = W'(v);
        lim_m[u] = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic open_cycle(input int cap, input logic [N-1:0] mask);
        @(negedge clk);
        cycle_start = 1'b1; cycle_cap = W'(cap); active_mask = mask;
        @(negedge clk);
        cycle_start = 1'b0;
        remain_m = cap; cap_m = cap;
        for (int i = 0; i < N; i++) begin
            act_m[i] = mask[i]; seen_m[i] = 1'b0; over_m[i] = 1'b0; ex_m[i] = 0;
        end
    endtask

    // Start pulse while the block is busy: the reference state is left alone
    task automatic stray_start(input int cap);
        @(negedge clk);
        cycle_start = 1'b1; cycle_cap = W'(cap); active_mask = '1;
        @(negedge clk);
        cycle_start = 1'b0;
    endtask

    task automatic send(input int u, input int b);
        bit ok;
        ok = (u < N) && act_m[u] && !seen_m[u];
        if (ok) begin
            int capd, g;
            seen_m[u] = 1'b1;
            capd = (b > lim_m[u]) ? lim_m[u] : b;
            g = (capd > remain_m) ? remain_m : capd;
            exp_u.push_back(u); exp_s.push_back(g);
            exp_f.push_back((b <= lim_m[u]) ? 1 : 0);
            exp_t.push_back("R2/R3/R11");
            remain_m -= g;
            if (b > lim_m[u]) begin
                over_m[u] = 1'b1; ex_m[u] = b - lim_m[u];
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_unit = IW'(u); req_bytes = W'(b);
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        if (ok) begin
            chk(gate_valid && int'(gate_unit) == u, "R1", "grant right after accept",
                $sformatf("valid %0d unit %0d", gate_valid, gate_unit),
                $sformatf("valid 1 unit %0d", u));
        end
    endtask

    task automatic close_cycle();
        int d0;
        for (int i = 0; i < N; i++) begin
            int u, g;
            u = (ptr_m + i) % N;
            if (act_m[u] && over_m[u]) begin
                g = (ex_m[u] > remain_m) ? remain_m : ex_m[u];
                exp_u.push_back(u); exp_s.push_back(g); exp_f.push_back(1);
                exp_t.push_back("R4/R5");
                remain_m -= g;
            end
        end
        ptr_m = (ptr_m + 1) % N;
        d0 = done_cnt;
        while (done_cnt == d0) @(negedge clk);
        @(negedge clk);
        #1;
        chk(!req_ready && !gate_valid && !cycle_done, "R8", "idle after done",
            $sformatf("%0d%0d%0d", req_ready, gate_valid, cycle_done), "000");
    endtask

    // Watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < N; i++) lim_m[i] = 0;
        repeat (4) @(negedge clk);
        #1;
        // R12: reset state
        chk(!gate_valid && !cycle_done && !req_ready, "R12", "reset outputs",
            $sformatf("%0d%0d%0d", gate_valid, cycle_done, req_ready), "000");
        rst_n = 1'b1;

        // R11: limits
        set_limit(0, 100); set_limit(1, 50); set_limit(2, 200);
        set_limit(3, 30);  set_limit(4, 80); set_limit(5, 10);

        // Mixed under/equal/over with ample capacity
        open_cycle(1000, 6'b111111);
        send(0, 80); send(1, 120); send(2, 200); send(3, 30); send(4, 100); send(5, 5);
        close_cycle();

        // R7 ignored requests, capacity exhaustion and zero grants, with backpressure
        bp_en = 1'b1;
        open_cycle(300, 6'b110111);
        send(3, 50); send(0, 150); send(0, 10); send(7, 20);
        send(1, 60); send(2, 100); send(4, 80); send(5, 40);
        close_cycle();
        bp_en = 1'b0;

        // R6: start pulse mid-cycle is ignored
        open_cycle(500, 6'b000110);
        send(2, 300);
        stray_start(9999);
        send(1, 90);
        close_cycle();

        // No over-limit unit; limit rewritten (R11)
        set_limit(3, 40);
        open_cycle(400, 6'b001001);
        send(0, 10); send(3, 30);
        close_cycle();

        // All over by small amounts, rotated order, backpressure
        bp_en = 1'b1;
        open_cycle(2000, 6'b111111);
        send(3, 44); send(5, 16); send(0, 101); send(2, 203); send(1, 52); send(4, 85);
        close_cycle();
        bp_en = 1'b0;

        // Tight capacity and pointer wrap
        open_cycle(20, 6'b100001);
        send(5, 20); send(0, 150);
        close_cycle();

        // Empty mask ends at once
        open_cycle(100, 6'b000000);
        close_cycle();

        // One more cycle after wrap to show pointer order
        open_cycle(1000, 6'b111111);
        send(0, 110); send(1, 60); send(2, 210); send(3, 50); send(4, 90); send(5, 20);
        close_cycle();

        finish_run();
    end

endmodule